// File: doc/BRIEF.md
# Character Display Start-Up Sequencer

This block runs once after reset on the host side of a character display module. It walks the display controller from an unknown power-on state to a fixed configuration. The first stage is three blind function-set writes, each followed by a fixed wait. In 4-bit bus mode a single-nibble width switch follows. The controller is then told the final bus width, line count and font. After that it receives display-off, clear and entry-mode commands.

The block issues bus cycles through a level request / done-pulse handshake to a separate bus-cycle engine, which owns the strobe and pin timing. Each transfer is either a full byte or one nibble, and is either a write or a status read. Every wait is a parameter in clock cycles, divided by a scale parameter so that simulation runs short. A parameter selects busy-flag polling for the commands after the final function set; otherwise fixed waits are used there too. When the entry-mode command completes, `ready_o` rises and stays high.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst_ni` is low, `bus_req_o` and `ready_o` are 0. After release, no request appears for at least the scaled power-up wait.
- R2: The first three transfers are writes of function-set code 0x3 in `bus_data_o[7:4]`. In 8-bit mode each is a byte transfer of 0x30 (`bus_nib_o`=0); in 4-bit mode each is a single nibble transfer (`bus_nib_o`=1, low nibble 0). The first two are followed by the scaled first and second waits.
- R3: In 4-bit mode, after the scaled command wait, exactly one nibble transfer of 0x2 follows the third write.
- R4: The final function set, preceded by the scaled command wait, is 0x20 | width<<4 | lines<<3 | font<<2. Here width is 1 for 8-bit, lines is 1 for two lines, and font is 1 for the tall font.
- R5: The remaining writes are, in order, 0x08 (display off), 0x01 (clear) and 0x04 | inc<<1 | shift.
- R6: In 4-bit mode every byte from the final function set on goes as two nibble transfers, upper nibble first, each in `bus_data_o[7:4]` with `bus_nib_o`=1. In 8-bit mode `bus_nib_o` is always 0.
- R7: Without polling, the display-off and clear writes come at least the scaled command wait after the previous write completes. The entry-mode write comes at least the scaled clear wait after the clear completes.
- R8: With polling, each of display off, clear and entry mode is preceded by status reads (`bus_rd_o`=1), repeated until bit 7 of the read byte is 0. In 4-bit mode that bit arrives in the first nibble of each pair. No read occurs before the final function set completes.
- R9: `ready_o` rises exactly one cycle after the done of the last entry-mode transfer and then stays high with no further requests.
- R10: A request holds `bus_rd_o`, `bus_nib_o` and `bus_data_o` stable until `bus_done_i`, and drops in the following cycle.
- R11: Each wait equals its cycle parameter divided by the scale parameter, with a minimum of 1. Each wait ends within four cycles of its nominal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_o | output | 1 | Transfer request to the bus-cycle engine, held until done |
| bus_rd_o | output | 1 | 1: status read, 0: instruction write |
| bus_nib_o | output | 1 | 1: single nibble transfer on bits 7:4 |
| bus_data_o | output | 8 | Write byte or nibble (in 7:4) |
| bus_done_i | input | 1 | One-cycle completion pulse from the engine |
| bus_rdata_i | input | 8 | Read data; bit 7 is the busy flag |
| ready_o | output | 1 | Start-up sequence complete |

## Verification
The hardest situation to reach from the ports is a busy flag that stays set across several polls in 4-bit mode. There the flag arrives only in the first nibble of each read pair, and the second nibble has to be ignored. The engine model in the bench reports busy for a fixed number of status bytes after every write. In the second nibble it returns data with bit 7 clear but other bits set, so a sequencer that sampled the wrong nibble or the wrong bit would leave the poll early and write too soon. Four configurations cover both bus widths, with and without polling, and differing line, font and entry bits. Every transfer is checked for its value and for its timing relative to the previous done.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [2:0] {
    ST_FS1, ST_FS2, ST_FS3, ST_SW4, ST_FSF, ST_OFF, ST_CLR, ST_ENT
  } step_e;

  typedef enum logic [2:0] {
    PH_WAIT, PH_WR, PH_XFER, PH_RD, PH_POLL, PH_READY
  } phase_e;

  typedef enum logic [2:0] {
    SP_IDLE, SP_HI, SP_GAP, SP_LO, SP_REST
  } split_e;

  function automatic logic [7:0] step_code(step_e s, bit bus8, bit two,
                                           bit tall, bit inc, bit sh);
    case (s)
      ST_FS1, ST_FS2, ST_FS3: return 8'h30;
      ST_SW4:                 return 8'h20;
      ST_FSF:                 return {3'b001, bus8, two, tall, 2'b00};
      ST_OFF:                 return 8'h08;
      ST_CLR:                 return 8'h01;
      default:                return {5'b00001, inc, sh, 1'b0} >> 1 | 8'h04;
    endcase
  endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_xfer_split.sv
module lcd_xfer_split
  import lcd_init_pkg::*;
#(
  parameter bit BUS_8BIT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       go_rd_i,
  input  logic       go_single_i,
  input  logic [7:0] go_byte_i,
  output logic       idle_o,
  output logic       fin_o,
  output logic       bf_o,
  output logic       bus_req_o,
  output logic       bus_rd_o,
  output logic       bus_nib_o,
  output logic [7:0] bus_data_o,
  input  logic       bus_done_i,
  input  logic [7:0] bus_rdata_i
);
  split_e     st_q;
  logic [3:0] lo_q;
  logic       last_q, cap_q;
  logic       unused_rdata;

  assign unused_rdata = ^bus_rdata_i[6:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SP_IDLE; bus_req_o <= 1'b0; bus_rd_o <= 1'b0; bus_nib_o <= 1'b0;
      bus_data_o <= '0; lo_q <= '0; last_q <= 1'b0; cap_q <= 1'b0;
    end else begin
      case (st_q)
        SP_IDLE: if (go_i) begin
          bus_req_o <= 1'b1;
          bus_rd_o  <= go_rd_i;
          st_q      <= SP_HI;
          if (BUS_8BIT) begin
            bus_data_o <= go_byte_i; bus_nib_o <= 1'b0; last_q <= 1'b1;
          end else begin
            bus_data_o <= {go_byte_i[7:4], 4'h0}; bus_nib_o <= 1'b1;
            lo_q <= go_byte_i[3:0]; last_q <= go_single_i;
          end
        end
        SP_HI: if (bus_done_i) begin
          bus_req_o <= 1'b0;
          cap_q     <= bus_rdata_i[7];
          st_q      <= last_q ? SP_REST : SP_GAP;
        end
        SP_GAP: begin
          bus_req_o  <= 1'b1;
          bus_data_o <= {lo_q, 4'h0};
          st_q       <= SP_LO;
        end
        SP_LO: if (bus_done_i) begin
          bus_req_o <= 1'b0;
          st_q      <= SP_REST;
        end
        default: st_q <= SP_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == SP_IDLE);
  assign fin_o  = bus_done_i & (((st_q == SP_HI) & last_q) | (st_q == SP_LO));
  // busy flag always comes from the first nibble of a pair
  assign bf_o   = (st_q == SP_LO) ? cap_q : bus_rdata_i[7];
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter bit          BUS_8BIT     = 1'b1,
  parameter bit          TWO_LINE     = 1'b1,
  parameter bit          FONT_TALL    = 1'b0,
  parameter bit          ENTRY_INC    = 1'b1,
  parameter bit          ENTRY_SHIFT  = 1'b0,
  parameter bit          POLL_BUSY    = 1'b0,
  parameter int unsigned WAIT_PWR_CYC = 1_600_000,
  parameter int unsigned WAIT_FS1_CYC = 420_000,
  parameter int unsigned WAIT_FS2_CYC = 11_000,
  parameter int unsigned WAIT_CMD_CYC = 4_000,
  parameter int unsigned WAIT_CLR_CYC = 160_000,
  parameter int unsigned TIME_DIV     = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       bus_req_o,
  output logic       bus_rd_o,
  output logic       bus_nib_o,
  output logic [7:0] bus_data_o,
  input  logic       bus_done_i,
  input  logic [7:0] bus_rdata_i,
  output logic       ready_o
);
  function automatic int unsigned scale(int unsigned c);
    return (c / TIME_DIV == 0) ? 1 : c / TIME_DIV;
  endfunction
  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned W_PWR = scale(WAIT_PWR_CYC);
  localparam int unsigned W_FS1 = scale(WAIT_FS1_CYC);
  localparam int unsigned W_FS2 = scale(WAIT_FS2_CYC);
  localparam int unsigned W_CMD = scale(WAIT_CMD_CYC);
  localparam int unsigned W_CLR = scale(WAIT_CLR_CYC);
  localparam int unsigned W_MAX = max2(max2(W_PWR, W_FS1), max2(max2(W_FS2, W_CMD), W_CLR));
  localparam int unsigned CNT_W = $clog2(W_MAX + 1);

  phase_e           phase_q, phase_d;
  step_e            step_q, step_d, step_nxt;
  logic             go, go_rd, go_single, tmr_load, tmr_done;
  logic             sp_idle, sp_fin, sp_bf;
  logic [7:0]       go_byte;
  logic [CNT_W-1:0] wait_val;

  function automatic logic [CNT_W-1:0] wait_after(step_e s);
    case (s)
      ST_FS1:  return CNT_W'(W_FS1);
      ST_FS2:  return CNT_W'(W_FS2);
      ST_CLR:  return CNT_W'(W_CLR);
      default: return CNT_W'(W_CMD);
    endcase
  endfunction

  assign step_nxt  = (step_q == ST_FS3 && BUS_8BIT) ? ST_FSF : step_e'(step_q + 3'd1);
  assign go_byte   = step_code(step_q, BUS_8BIT, TWO_LINE, FONT_TALL, ENTRY_INC, ENTRY_SHIFT);
  assign go_single = !BUS_8BIT && (step_q <= ST_SW4);
  assign wait_val  = wait_after(step_q);

  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    go       = 1'b0;
    go_rd    = 1'b0;
    tmr_load = 1'b0;
    case (phase_q)
      PH_WAIT: if (tmr_done) phase_d = PH_WR;
      PH_WR:   if (sp_idle) begin go = 1'b1; phase_d = PH_XFER; end
      PH_RD:   if (sp_idle) begin go = 1'b1; go_rd = 1'b1; phase_d = PH_POLL; end
      PH_POLL: if (sp_fin) phase_d = sp_bf ? PH_RD : PH_WR;
      PH_XFER: if (sp_fin) begin
        if (step_q == ST_ENT) phase_d = PH_READY;
        else begin
          step_d = step_nxt;
          if (POLL_BUSY && step_nxt >= ST_OFF) phase_d = PH_RD;
          else begin tmr_load = 1'b1; phase_d = PH_WAIT; end
        end
      end
      default: phase_d = PH_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      step_q  <= ST_FS1;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

  assign ready_o = (phase_q == PH_READY);

  lcd_wait_timer #(.CNT_W(CNT_W), .RST_VAL(W_PWR)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(wait_val), .done_o(tmr_done)
  );

  lcd_xfer_split #(.BUS_8BIT(BUS_8BIT)) i_split (
    .clk_i, .rst_ni,
    .go_i(go), .go_rd_i(go_rd), .go_single_i(go_single), .go_byte_i(go_byte),
    .idle_o(sp_idle), .fin_o(sp_fin), .bf_o(sp_bf),
    .bus_req_o, .bus_rd_o, .bus_nib_o, .bus_data_o, .bus_done_i, .bus_rdata_i
  );
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter bit BUS_8BIT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_req_o,
  input logic       bus_rd_o,
  input logic       bus_nib_o,
  input logic [7:0] bus_data_o,
  input logic       bus_done_i,
  input logic [7:0] bus_rdata_i,
  input logic       ready_o
);
  localparam int unsigned FS_WRITES = BUS_8BIT ? 4 : 6;

  logic [3:0] wr_cnt_q;
  logic       unused_rd;
  assign unused_rd = ^bus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_cnt_q <= '0;
    else if (bus_done_i && bus_req_o && !bus_rd_o && wr_cnt_q != 4'hF)
      wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_data_o) && $stable(bus_rd_o) && $stable(bus_nib_o)); // R10
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_done_i |=> !bus_req_o); // R10
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R9
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !bus_req_o); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(bus_done_i)); // R9
  AST_NIB_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && BUS_8BIT |-> !bus_nib_o); // R6
  AST_NO_EARLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_rd_o |-> wr_cnt_q >= 4'(FS_WRITES)); // R8
endmodule

bind lcd_init_seq lcd_init_seq_chk #(.BUS_8BIT(BUS_8BIT)) i_chk (.*);

// File: tb/test_lcd_init_seq.sv
module lcd_init_harness #(
  parameter int CFG = 0
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic fin_o
);
  localparam bit BUS8  = !CFG[0];
  localparam bit POLL  = CFG[1];
  localparam bit TWO   = !(CFG[0] ^ CFG[1]);
  localparam bit TALL  = CFG[0] ^ CFG[1];
  localparam bit INC   = !CFG[0];
  localparam bit SH    = CFG[0] ^ CFG[1];
  localparam int DIV   = 4;
  localparam int P_PWR = 400, P_FS1 = 120, P_FS2 = 40, P_CMD = 12, P_CLR = 60;
  localparam int LAT   = 3;
  localparam int BUSY_N = 2;

  logic       req, rd, nib, ready, done;
  logic [7:0] data, rdata;
  int         cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  lcd_init_seq #(
    .BUS_8BIT(BUS8), .TWO_LINE(TWO), .FONT_TALL(TALL), .ENTRY_INC(INC),
    .ENTRY_SHIFT(SH), .POLL_BUSY(POLL), .WAIT_PWR_CYC(P_PWR),
    .WAIT_FS1_CYC(P_FS1), .WAIT_FS2_CYC(P_FS2), .WAIT_CMD_CYC(P_CMD),
    .WAIT_CLR_CYC(P_CLR), .TIME_DIV(DIV)
  ) i_lcd_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_o(req), .bus_rd_o(rd),
    .bus_nib_o(nib), .bus_data_o(data), .bus_done_i(done),
    .bus_rdata_i(rdata), .ready_o(ready)
  );

  logic [7:0] e_dat [16];
  bit         e_nib [16];
  int         e_gap [16];
  bit         e_pol [16];
  string      e_tag [16];
  string      e_gtg [16];
  int         ne = 0;

  function automatic int weff(int c);
    return (c / DIV == 0) ? 1 : c / DIV;
  endfunction

  task automatic push(logic [7:0] d, bit n, int g, bit p, string t, string gt);
    e_dat[ne] = d; e_nib[ne] = n; e_gap[ne] = g; e_pol[ne] = p;
    e_tag[ne] = t; e_gtg[ne] = gt; ne++;
  endtask

  task automatic push_byte(logic [7:0] b, int g, bit p, string t, string gt);
    if (BUS8) push(b, 1'b0, g, p, t, gt);
    else begin
      push({b[7:4], 4'h0}, 1'b1, g, p, t, gt);
      push({b[3:0], 4'h0}, 1'b1, 0, 1'b0, {t, " R6"}, "R6");
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL cfg%0d %s actual=%0h expected=%0h", CFG, tag, act, exp);
    end
  endtask

  int idx, rdcnt, last_t;
  bit par;

  task automatic xfer();
    int         t0, g;
    logic [7:0] d;
    bit         n, r, ok, first, last;
    t0 = cyc; d = data; n = nib; r = rd; ok = 1'b1; last = 1'b0;
    if (!r) begin
      g = t0 - last_t;
      if (idx < ne)
        chk(g >= e_gap[idx] + 1 && g <= e_gap[idx] + 4, {e_gtg[idx], " gap"}, g, e_gap[idx]);
    end
    for (int k = 0; k < LAT - 1; k++) begin
      @(negedge clk);
      if (!req || data != d || nib != n || rd != r) ok = 1'b0;
    end
    chk(ok, "R10 request held", 0, 0);
    if (r) begin
      first = BUS8 || !par;
      rdata = first ? {rdcnt < BUSY_N, 7'h55} : 8'h50;
      if (first) rdcnt++;
      par = BUS8 ? 1'b0 : !par;
    end else begin
      if (idx < ne) begin
        chk(d == e_dat[idx] && n == e_nib[idx], e_tag[idx], {n, d}, {e_nib[idx], e_dat[idx]});
        chk(rdcnt == (e_pol[idx] ? BUSY_N + 1 : 0), "R8 status reads", rdcnt,
            e_pol[idx] ? BUSY_N + 1 : 0);
      end else chk(1'b0, "R5 extra write", d, 0);
      last = (idx == ne - 1);
      rdcnt = 0; par = 1'b0; idx++;
    end
    done = 1'b1;
    last_t = cyc;
    if (last) chk(!ready, "R9 ready early", ready, 0);
    @(negedge clk);
    done = 1'b0;
    chk(!req, "R10 request drop", req, 0);
    if (last) chk(ready, "R9 ready", ready, 1);
  endtask

  initial begin
    bit ok;
    n_chk = 0; n_fail = 0; fin_o = 1'b0; done = 1'b0; rdata = '0;
    push(8'h30, !BUS8, weff(P_PWR), 1'b0, "R2", "R1 R11");
    push(8'h30, !BUS8, weff(P_FS1), 1'b0, "R2", "R2 R11");
    push(8'h30, !BUS8, weff(P_FS2), 1'b0, "R2", "R2 R11");
    if (!BUS8) push(8'h20, 1'b1, weff(P_CMD), 1'b0, "R3", "R3");
    push_byte({3'b001, BUS8, TWO, TALL, 2'b00}, weff(P_CMD), 1'b0, "R4", "R4");
    push_byte(8'h08, POLL ? 0 : weff(P_CMD), POLL, "R5", "R7");
    push_byte(8'h01, POLL ? 0 : weff(P_CMD), POLL, "R5", "R7");
    push_byte({5'b00001, INC, SH, 1'b0} >> 1, POLL ? 0 : weff(P_CLR), POLL, "R5", "R7");
    @(negedge clk);
    chk(!req && !ready, "R1 reset state", {req, ready}, 0);
    wait (rst_n === 1'b1);
    last_t = cyc; idx = 0; rdcnt = 0; par = 1'b0;
    while (idx < ne) begin
      @(negedge clk);
      if (req) xfer();
    end
    ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (req || !ready) ok = 1'b0;
    end
    chk(ok, "R9 ready held, no request", 0, 0);
    fin_o = 1'b1;
  end
endmodule

module test_lcd_init_seq;
  logic clk = 1'b0;
  logic rst_n;
  int   chk_a [4];
  int   fail_a [4];
  logic fin_a [4];

  always #2 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_cfg
    lcd_init_harness #(.CFG(g)) u_h (
      .clk(clk), .rst_n(rst_n), .n_chk(chk_a[g]), .n_fail(fail_a[g]), .fin_o(fin_a[g])
    );
  end

  initial begin
    int tot, bad, w;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    w = 0;
    while (!(fin_a[0] && fin_a[1] && fin_a[2] && fin_a[3]) && w < 20000) begin
      @(negedge clk);
      w++;
    end
    tot = 0; bad = 0;
    for (int i = 0; i < 4; i++) begin
      tot += chk_a[i];
      bad += fail_a[i];
    end
    if (w >= 20000) begin
      tot++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=done", w);
    end
    $display("  [TB] %0d tests run, %0d failed", tot, bad);
    $finish;
  end
endmodule